// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one accepted burst request into the run of column addresses that a synchronous DRAM controller places on the bus, one per clock. A request is a single-cycle start pulse carrying a starting column, a read/write flag and the current mode-register word. The block picks out the burst-length code, the ordering bit and the write-single bit from that word. It then walks through the columns of the burst, either in linear order or in XOR-interleaved order. The walk never leaves the naturally aligned block that contains the starting column.

A full-page setting gives an open-ended linear walk over the whole row that wraps at the row end. Only the terminate input or a new start ends it. A mode word that encodes an unsupported length, or full page combined with interleave, raises an error flag and produces a single beat. Command issue, bank and row tracking, refresh and data movement belong to neighbouring blocks.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after reset releases, `beat_valid_o`, `beat_last_o` and `mode_err_o` are low until a start is accepted.
- R2: A start pulse sampled on a clock edge makes `beat_valid_o` high from the next cycle, with `col_o` equal to `start_col_i` on that first beat. After the final beat, `beat_valid_o` is low.
- R3: The length code in mode bits [2:0] sets the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8.
- R4: With mode bit 3 = 0 (linear order), the low log2(length) column bits advance by one per beat, modulo the length. The bits above them stay equal to those of the starting column. For example, a start offset of 2 with length 4 gives offsets 2,3,0,1.
- R5: With mode bit 3 = 1 (interleaved order), the low log2(length) column bits on beat k equal the start offset XOR k. The upper bits are kept, as in R4.
- R6: Code 111 with mode bit 3 = 0 selects full page: the column increments by one per beat modulo 512 from any start column, with no end. `beat_last_o` stays low unless terminate is high.
- R7: With length 1, exactly one beat at the starting column is produced, whatever mode bit 3 holds.
- R8: When mode bit 9 = 1, a write request (`is_write_i` = 1) produces a single beat at the starting column. A read request under the same mode word uses the programmed length.
- R9: Codes 100, 101 and 110, and code 111 with mode bit 3 = 1, make `mode_err_o` high from the first beat until the next accepted start, and the burst is a single beat.
- R10: `term_i` high during a valid beat makes that beat the last one: `beat_last_o` is high in that cycle and `beat_valid_o` is low in the next, unless a start is sampled.
- R11: A start sampled during a burst restarts the sequence at the new column on the next cycle. A start takes priority over terminate or the natural end in the same cycle.
- R12: `beat_last_o` is high on the final beat of every finite burst and low on all other beats unless terminate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle burst request |
| is_write_i | input | 1 | 1 = write request, 0 = read request |
| start_col_i | input | 9 | Starting column of the burst |
| mode_i | input | 13 | Mode word; bits [2:0] length code, bit 3 ordering, bit 9 write-single |
| term_i | input | 1 | Ends the running burst after the current beat |
| col_o | output | 9 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | The current beat is the final one |
| mode_err_o | output | 1 | The current or most recent burst used an invalid mode word |

## Verification
Three events can fall in the same cycle, and these cases get the most attention. A terminate can meet the natural last beat of a finite burst, a new start can arrive while a burst is running, and a start and a terminate can arrive together. The bench drives terminate exactly on the final beat of a finite burst, and asserts start together with terminate in the middle of a full-page walk. It judges each cycle against a behavioural reference model. In that model, start outranks both ends of the old burst, and the last flag follows terminate in the same cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // Field positions inside the mode word consumed by the sequencer.
  localparam int LEN_LSB    = 0;
  localparam int ORDER_BIT  = 3;
  localparam int WSINGLE_BIT = 9;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;
endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
  import bcg_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 13,
  localparam int LG_W  = $clog2(COL_W + 1)
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_write_i,
  output logic [LG_W-1:0]   lg_o,
  output logic              inter_o,
  output logic              full_o,
  output logic              err_o
);
  logic [2:0]      code;
  logic            order_bit;
  logic            wsingle;
  logic [LG_W-1:0] lg_raw;
  logic            full_raw;
  logic            bad;

  assign code      = mode_i[LEN_LSB +: 3];
  assign order_bit = mode_i[ORDER_BIT];
  assign wsingle   = mode_i[WSINGLE_BIT];

  always_comb begin
    lg_raw   = '0;
    full_raw = 1'b0;
    bad      = 1'b0;
    unique case (code)
      LEN_ONE:   lg_raw = LG_W'(0);
      LEN_TWO:   lg_raw = LG_W'(1);
      LEN_FOUR:  lg_raw = LG_W'(2);
      LEN_EIGHT: lg_raw = LG_W'(3);
      LEN_PAGE: begin
        if (order_bit) begin
          bad = 1'b1;
        end else begin
          lg_raw   = LG_W'(COL_W);
          full_raw = 1'b1;
        end
      end
      default: bad = 1'b1;
    endcase
  end

  always_comb begin
    lg_o    = lg_raw;
    full_o  = full_raw;
    inter_o = order_bit;
    err_o   = bad;
    if (bad || (is_write_i && wsingle)) begin
      lg_o   = '0;
      full_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int COL_W = 9,
  localparam int LG_W = $clog2(COL_W + 1)
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             inter_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_mix;

  assign lin_sum = base_i + idx_i;
  assign xor_mix = base_i ^ idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic in_block;
    assign in_block = (lg_i > LG_W'(b));
    always_comb begin
      if (!in_block)    col_o[b] = base_i[b];
      else if (inter_i) col_o[b] = xor_mix[b];
      else              col_o[b] = lin_sum[b];
    end
  end
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq #(
  parameter int COL_W = 9,
  localparam int LG_W = $clog2(COL_W + 1),
  localparam int CW1  = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             inter_i,
  input  logic             full_i,
  input  logic             err_i,
  input  logic             term_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic [LG_W-1:0]  lg_o,
  output logic             inter_o,
  output logic             full_o,
  output logic             err_o,
  output logic             last_o
);
  logic             active_q, active_d;
  logic [COL_W-1:0] base_q,   base_d;
  logic [COL_W-1:0] idx_q,    idx_d;
  logic [LG_W-1:0]  lg_q,     lg_d;
  logic             inter_q,  inter_d;
  logic             full_q,   full_d;
  logic             err_q,    err_d;
  logic             load_en;
  logic             step_en;
  logic [CW1-1:0]   span;
  logic             fin_end;

  assign span    = CW1'(1) << lg_q;
  assign mask_o  = COL_W'(span - CW1'(1));
  assign fin_end = active_q && !full_q && (idx_q == mask_o);

  assign load_en = start_i;
  assign step_en = !start_i && active_q;

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    idx_d    = idx_q;
    lg_d     = lg_q;
    inter_d  = inter_q;
    full_d   = full_q;
    err_d    = err_q;
    if (load_en) begin
      active_d = 1'b1;
      base_d   = start_col_i;
      idx_d    = '0;
      lg_d     = lg_i;
      inter_d  = inter_i;
      full_d   = full_i;
      err_d    = err_i;
    end else if (step_en) begin
      if (term_i || fin_end) active_d = 1'b0;
      else                   idx_d    = idx_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      lg_q     <= '0;
      inter_q  <= 1'b0;
      full_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      if (load_en || step_en) begin
        base_q  <= base_d;
        idx_q   <= idx_d;
        lg_q    <= lg_d;
        inter_q <= inter_d;
        full_q  <= full_d;
        err_q   <= err_d;
      end
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign lg_o     = lg_q;
  assign inter_o  = inter_q;
  assign full_o   = full_q;
  assign err_o    = err_q;
  assign last_o   = active_q && (fin_end || term_i);

  p_start_gives_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_q);
  p_term_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && term_i && !start_i) |=> !active_q);
  p_idx_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_q) |-> (idx_q <= mask_o));
  p_restart_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (idx_q == '0));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 9,
  parameter int MODE_W = 13,
  localparam int LG_W  = $clog2(COL_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              beat_last_o,
  output logic              mode_err_o
);
  logic             rst_n_int;
  logic [LG_W-1:0]  dec_lg;
  logic             dec_inter;
  logic             dec_full;
  logic             dec_err;
  logic             act;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] mask;
  logic [LG_W-1:0]  lg;
  logic             inter;
  logic             full;
  logic             err;
  logic             last;

  bcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bcg_mode_decode #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dec (
    .mode_i     (mode_i),
    .is_write_i (is_write_i),
    .lg_o       (dec_lg),
    .inter_o    (dec_inter),
    .full_o     (dec_full),
    .err_o      (dec_err)
  );

  bcg_seq #(.COL_W(COL_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .lg_i        (dec_lg),
    .inter_i     (dec_inter),
    .full_i      (dec_full),
    .err_i       (dec_err),
    .term_i      (term_i),
    .active_o    (act),
    .base_o      (base),
    .idx_o       (idx),
    .mask_o      (mask),
    .lg_o        (lg),
    .inter_o     (inter),
    .full_o      (full),
    .err_o       (err),
    .last_o      (last)
  );

  bcg_col_map #(.COL_W(COL_W)) u_map (
    .base_i  (base),
    .idx_i   (idx),
    .lg_i    (lg),
    .inter_i (inter),
    .col_o   (col_o)
  );

  assign beat_valid_o = act;
  assign beat_last_o  = last;
  assign mode_err_o   = err;

  p_block_kept_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (beat_valid_o && !full) |-> (((col_o ^ base) & ~mask) == '0));
  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (beat_valid_o && mode_err_o) |-> beat_last_o);
  p_page_open_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (beat_valid_o && full && !term_i) |-> !beat_last_o);
  p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (start_i && !beat_valid_o) |=> (col_o == $past(start_col_i)));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        is_write_i = 1'b0;
  logic [8:0]  start_col_i = '0;
  logic [12:0] mode_i = '0;
  logic        term_i = 1'b0;
  logic [8:0]  col_o;
  logic        beat_valid_o;
  logic        beat_last_o;
  logic        mode_err_o;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  bit m_act = 0;
  int m_base = 0, m_idx = 0, m_len = 1;
  bit m_inter = 0, m_full = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .start_col_i(start_col_i), .mode_i(mode_i), .term_i(term_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .beat_last_o(beat_last_o),
    .mode_err_o(mode_err_o)
  );

  function automatic logic [12:0] mk(int code, bit order, bit wsingle);
    logic [12:0] w = '0;
    w[2:0] = code[2:0];
    w[3]   = order;
    w[9]   = wsingle;
    return w;
  endfunction

  task automatic chk(string tag, int act_v, int exp_v, string what);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  function automatic int exp_col();
    int off = m_base % m_len;
    int blk = m_base - off;
    if (m_inter) return blk + (off ^ m_idx);
    return blk + ((off + m_idx) % m_len);
  endfunction

  task automatic model_load(bit wr, int col, logic [12:0] md);
    int code = int'(md[2:0]);
    m_act = 1; m_base = col; m_idx = 0;
    m_inter = md[3]; m_full = 0; m_err = 0;
    case (code)
      0: m_len = 1;
      1: m_len = 2;
      2: m_len = 4;
      3: m_len = 8;
      7: if (md[3]) m_err = 1; else begin m_len = 512; m_full = 1; end
      default: m_err = 1;
    endcase
    if (m_err) m_len = 1;
    if (wr && md[9]) begin m_len = 1; m_full = 0; end
  endtask

  // One cycle: drive at negedge, compare, then advance model at posedge.
  task automatic step(bit st, bit wr, int col, logic [12:0] md, bit tm, string tag);
    bit el;
    @(negedge clk);
    start_i = st; is_write_i = wr; start_col_i = col[8:0]; mode_i = md; term_i = tm;
    #1;
    el = m_act && ((!m_full && m_idx == m_len - 1) || tm);
    chk(tag, int'(beat_valid_o), int'(m_act), "valid");
    if (m_act) chk(tag, int'(col_o), exp_col(), "col");
    chk(tag, int'(beat_last_o), int'(el), "last");
    chk(tag, int'(mode_err_o), int'(m_err), "err");
    @(posedge clk);
    if (rst_n) begin
      if (st) model_load(wr, col, md);
      else if (m_act) begin
        if (tm || (!m_full && m_idx == m_len - 1)) m_act = 0;
        else m_idx = (m_idx + 1) % 512;
      end
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(3, "R1");
    @(negedge clk) rst_n = 1'b1;
    idle(4, "R1");

    // R2 R3 R4 R12: linear length 4, start offset 2 -> 2,3,0,1
    step(1, 0, 9'h0A2, mk(2, 0, 0), 0, "R4");
    idle(6, "R4");
    // R3: lengths 1, 2, 8 linear
    step(1, 0, 9'h133, mk(0, 0, 0), 0, "R3");
    idle(3, "R3");
    step(1, 0, 9'h07B, mk(1, 0, 0), 0, "R3");
    idle(4, "R3");
    step(1, 0, 9'h0FE, mk(3, 0, 0), 0, "R12");
    idle(10, "R12");
    // R5: interleaved length 8 start offset 5, and length 4, 2
    step(1, 0, 9'h1F5, mk(3, 1, 0), 0, "R5");
    idle(10, "R5");
    step(1, 0, 9'h047, mk(2, 1, 0), 0, "R5");
    idle(5, "R5");
    step(1, 0, 9'h011, mk(1, 1, 0), 0, "R5");
    idle(3, "R5");
    // R7: length 1 with interleave bit set
    step(1, 0, 9'h155, mk(0, 1, 0), 0, "R7");
    idle(3, "R7");
    // R6: full page from 0x1FD wraps past 511, then terminate (R10)
    step(1, 0, 9'h1FD, mk(7, 0, 0), 0, "R6");
    idle(12, "R6");
    step(0, 0, 0, '0, 1, "R10");
    idle(3, "R10");
    // R8: write-single bit: write one beat, read full length
    step(1, 1, 9'h0C3, mk(3, 0, 1), 0, "R8");
    idle(3, "R8");
    step(1, 0, 9'h0C3, mk(3, 0, 1), 0, "R8");
    idle(10, "R8");
    step(1, 1, 9'h0C3, mk(3, 0, 0), 0, "R8");
    idle(10, "R8");
    // R9: reserved codes and page with interleave
    step(1, 0, 9'h0AA, mk(4, 0, 0), 0, "R9");
    idle(3, "R9");
    step(1, 0, 9'h0AB, mk(6, 1, 0), 0, "R9");
    idle(2, "R9");
    step(1, 0, 9'h0AC, mk(7, 1, 0), 0, "R9");
    idle(3, "R9");
    step(1, 0, 9'h0AD, mk(1, 0, 0), 0, "R9");
    idle(4, "R9");
    // R10: terminate mid length 8, and terminate on the natural last beat
    step(1, 0, 9'h010, mk(3, 0, 0), 0, "R10");
    idle(2, "R10");
    step(0, 0, 0, '0, 1, "R10");
    idle(3, "R10");
    step(1, 0, 9'h020, mk(1, 0, 0), 0, "R10");
    idle(1, "R10");
    step(0, 0, 0, '0, 1, "R10");
    idle(3, "R10");
    // R11: restart mid burst, then start together with terminate in full page
    step(1, 0, 9'h101, mk(3, 1, 0), 0, "R11");
    idle(3, "R11");
    step(1, 0, 9'h1E6, mk(2, 0, 0), 0, "R11");
    idle(2, "R11");
    step(1, 0, 9'h050, mk(7, 0, 0), 0, "R11");
    idle(5, "R11");
    step(1, 0, 9'h0F3, mk(3, 0, 0), 1, "R11");
    idle(10, "R11");
    // R11: start on the natural last beat
    step(1, 0, 9'h030, mk(1, 0, 0), 0, "R11");
    idle(1, "R11");
    step(1, 0, 9'h032, mk(1, 1, 0), 0, "R11");
    idle(4, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule